// File: doc/BRIEF.md
# Polled Byte-Wide SPI Master

This block is a programmed-I/O SPI master that sits on a simple 32-bit register bus and moves exactly one byte per command. Software loads the byte to send into the data word, then writes the control word with the start bit set. The control word also carries the select lines, the clock mode and the clock divider. The block then drives eight serial clock cycles on `sclk_o`. It shifts the byte out most significant bit first on `mosi_o` and collects eight bits from `miso_i`. While it does this it reports busy. When busy drops, the data word holds the received byte.

The bus has one write port and one read port. A write takes effect on the clock edge where `bus_en` and `bus_we` are both high. A read is combinational: `bus_rdata` follows `bus_addr` at every moment. Byte offset 0x0 selects the control/status word and byte offset 0x4 selects the data word. Only address bit 2 is decoded.

The three select outputs are plain register bits. They are updated by every control write, so software sets a select level before a byte and clears it after. The serial clock runs at the reference clock divided by 2 × (divider + 1). A loopback mode feeds the outgoing bit stream back into the receiver.

The command path has no back-pressure. Software polls the busy bit before it issues the next command. A data write made while busy is dropped. A start request made while busy is also dropped.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, `cs_o` is all ones and busy is 0. The control word reads `(RESET_DIV << 27) | 0x15`, the data word reads 0, and `sclk_o` is 0.
- R2: A control write with bit 1 set while idle starts a transfer. Control bit 1 reads 1 from the next cycle. It stays 1 for exactly 16 × (div + 1) cycles, where div is control bits 31:27.
- R3: Every control write copies bit 0 to `cs_o[0]`, bit 2 to `cs_o[1]` and bit 4 to `cs_o[2]`. This takes effect from the next cycle, whether or not a transfer is running.
- R4: With loopback (control bit 3) set, the received byte equals the transmitted byte, and `miso_i` has no effect.
- R5: Control bit 5 (CPOL) sets the idle level of `sclk_o`. A transfer makes exactly 16 edges on `sclk_o` and leaves it at the idle level.
- R6: The transmit byte leaves MSB first on `mosi_o`. With CPHA (control bit 6) clear, bits are sampled on leading edges and change on trailing edges. With CPHA set, they change on leading edges (after the first) and are sampled on trailing edges. The byte sent by a device on `miso_i` MSB first ends up in data bits 7:0.
- R7: Each half period of `sclk_o` lasts div + 1 reference cycles, where div is control bits 31:27. The serial clock therefore runs at the reference rate / (2 × (div + 1)).
- R8: While busy, a data write is ignored. A control write during a transfer neither restarts it nor changes loopback, CPOL or CPHA. It still updates the selects and the divider.
- R9: The data word reads the byte in bits 7:0 and zero in bits 31:8. After a transfer it holds the received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write enable, qualified by bus_en |
| bus_addr | input | ADDR_W | Byte address; bit 2 selects the data word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| cs_o | output | NUM_CS | Select lines, direct copies of control bits 0, 2, 4 |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The bench builds the block with its default parameters. These are a 5-bit divider field, three selects, and a reset divider of 31, so the reset-state readback and one full-length slow transfer of 512 cycles are checked as they are. The vector table programs small divider values of 0 to 4. These keep the remaining transfers short while they still cover every CPOL/CPHA combination, loopback, and the exact busy length for each divider. A bench-side serial device model produces `miso_i` and captures `mosi_o` on the sampling edge of the active mode.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int GO_BIT   = 1;
  localparam int LOOP_BIT = 3;
  localparam int CPOL_BIT = 5;
  localparam int CPHA_BIT = 6;

  typedef struct packed {
    logic loop;
    logic cpol;
    logic cpha;
  } xfer_mode_t;

  function automatic int sel_bit(input int n);
    return 2 * n;
  endfunction
endpackage

// File: rtl/spim_divider.sv
module spim_divider #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!run)       cnt_q <= '0;
    else if (tick)       cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  // R7: after a half-period tick the next one is at least div+1 cycles away
  p_tick_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (!tick || div == '0));
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
  import spim_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] tx_byte,
  input  xfer_mode_t        mode,
  input  logic              tick,
  input  logic              miso_i,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic              done,
  output logic [BYTE_W-1:0] rx_final
);
  localparam int EDGES  = 2 * BYTE_W;
  localparam int EDGE_W = $clog2(EDGES);

  logic [EDGE_W-1:0] edge_q;
  logic [BYTE_W-1:0] tx_q, rx_q;
  logic              sclk_q;
  xfer_mode_t        mode_q;
  logic              leading, do_sample, do_shift, miso_eff;

  assign leading   = ~edge_q[0];
  assign do_sample = mode_q.cpha ? ~leading : leading;
  assign do_shift  = mode_q.cpha ? (leading && edge_q != '0) : ~leading;
  assign mosi      = tx_q[BYTE_W-1];
  assign miso_eff  = mode_q.loop ? tx_q[BYTE_W-1] : miso_i;
  assign done      = busy && tick && (edge_q == EDGE_W'(EDGES - 1));
  assign rx_final  = do_sample ? {rx_q[BYTE_W-2:0], miso_eff} : rx_q;
  assign sclk      = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      edge_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      sclk_q <= 1'b0;
      mode_q <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      edge_q <= '0;
      tx_q   <= tx_byte;
      rx_q   <= '0;
      sclk_q <= mode.cpol;
      mode_q <= mode;
    end else if (busy && tick) begin
      sclk_q <= ~sclk_q;
      edge_q <= edge_q + 1'b1;
      if (do_sample) rx_q <= rx_final;
      if (do_shift)  tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
      if (done)      busy <= 1'b0;
    end
  end

  // R5: after the final edge the clock rests at the latched idle level
  p_idle_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (sclk_q == mode_q.cpol));
  // R2: a transfer never ends in the cycle right after it started
  p_no_instant_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> !done);
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spim_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 3,
  parameter int NUM_CS    = 3,
  parameter int DIV_W     = 5,
  parameter int BYTE_W    = 8,
  parameter int RESET_DIV = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CS-1:0] cs_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  localparam int DIV_LSB = DATA_W - DIV_W;

  logic              wr_ctrl, wr_data, go, busy, tick, done, sclk_sh;
  logic [DIV_W-1:0]  div_q;
  logic [BYTE_W-1:0] data_q, rx_final;
  xfer_mode_t        mode_q, mode_wr;
  logic [DATA_W-1:0] ctrl_rd;
  logic              unused_bits;

  assign wr_ctrl = bus_en && bus_we && !bus_addr[2];
  assign wr_data = bus_en && bus_we &&  bus_addr[2];
  assign go      = wr_ctrl && bus_wdata[GO_BIT] && !busy;
  assign mode_wr = '{loop: bus_wdata[LOOP_BIT], cpol: bus_wdata[CPOL_BIT],
                     cpha: bus_wdata[CPHA_BIT]};
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[DIV_LSB-1:CPHA_BIT+1],
                         bus_wdata[ADDR_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= DIV_W'(RESET_DIV);
      mode_q <= '0;
      data_q <= '0;
    end else begin
      if (wr_ctrl) begin
        div_q <= bus_wdata[DATA_W-1:DIV_LSB];
        if (!busy) mode_q <= mode_wr;
      end
      if (done)                  data_q <= rx_final;
      else if (wr_data && !busy) data_q <= bus_wdata[BYTE_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_sel
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cs_o[g] <= 1'b1;
      else if (wr_ctrl) cs_o[g] <= bus_wdata[sel_bit(g)];
    end
    // R3: each select follows its control bit after every control write
    p_sel_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> cs_o[g] == $past(bus_wdata[sel_bit(g)]));
  end

  always_comb begin
    ctrl_rd = '0;
    for (int n = 0; n < NUM_CS; n++) ctrl_rd[sel_bit(n)] = cs_o[n];
    ctrl_rd[GO_BIT]   = busy;
    ctrl_rd[LOOP_BIT] = mode_q.loop;
    ctrl_rd[CPOL_BIT] = mode_q.cpol;
    ctrl_rd[CPHA_BIT] = mode_q.cpha;
    ctrl_rd[DATA_W-1:DIV_LSB] = div_q;
  end

  assign bus_rdata = bus_addr[2] ? {{(DATA_W-BYTE_W){1'b0}}, data_q} : ctrl_rd;
  assign sclk_o    = busy ? sclk_sh : mode_q.cpol;

  spim_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q), .tick(tick)
  );

  spim_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(go), .tx_byte(data_q), .mode(mode_wr),
    .tick(tick), .miso_i(miso_i), .busy(busy), .sclk(sclk_sh),
    .mosi(mosi_o), .done(done), .rx_final(rx_final)
  );

  // R2: an accepted start shows busy in the following cycle
  p_go_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy);
  // R8: data word is frozen against bus writes during a transfer
  p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && busy && !done) |=> $stable(data_q));
  // R8: mode bits do not change while a transfer runs
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && busy) |=> $stable(mode_q));
  // R9: upper data bits always read zero
  p_rd_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr[2] |-> bus_rdata[DATA_W-1:BYTE_W] == '0);
endmodule

// File: tb/tb_spi_byte_master.sv
module tb_spi_byte_master;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        bus_en = 0, bus_we = 0;
  logic [2:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [2:0]  cs_o;
  logic        sclk_o, mosi_o, miso_i;

  int total = 0, bad = 0, cyc = 0;
  int edges = 0, idx = 8;
  logic       m_cpol = 0, m_cpha = 0;
  logic [7:0] pat = 0, cap = 0;

  spi_byte_master dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cs_o(cs_o), .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // serial device model: drives pat MSB first, captures mosi on sampling edge
  assign miso_i = (idx >= 0 && idx <= 7) ? pat[idx] : 1'b0;
  always @(sclk_o) begin
    logic lead;
    lead = (sclk_o !== m_cpol);
    edges = edges + 1;
    if (m_cpha ? !lead : lead) cap = {cap[6:0], mosi_o};
    if (m_cpha ? lead : !lead) idx = idx - 1;
  end

  // vector: [28:24] div, [18] loop, [17] cpha, [16] cpol, [15:8] tx, [7:0] pat
  localparam logic [31:0] VEC [6] = '{
    32'h0000_A53C, 32'h0101_81C3, 32'h0202_5A96,
    32'h0303_FF01, 32'h0004_6EFF, 32'h0407_00A5
  };

  function automatic logic [31:0] ctrl(input logic [2:0] cs, input logic go,
      input logic loop, input logic cpol, input logic cpha, input logic [4:0] dv);
    return {dv, 20'd0, cpha, cpol, cs[2], loop, cs[1], go, cs[0]};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0; bus_addr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    bus_addr = a; #1 v = bus_rdata; bus_addr = 0; #1;
  endtask

  task automatic wait_idle(input int t0, output int n);
    logic [31:0] v;
    forever begin
      rd(3'd0, v);
      if (!v[1]) break;
      if (cyc - t0 > 20000) begin
        chk(0, "watch busy", v, 0);
        break;
      end
      @(negedge clk);
    end
    n = cyc - t0;
  endtask

  task automatic arm(input logic cpol, input logic cpha, input logic [7:0] p);
    m_cpol = cpol; m_cpha = cpha; pat = p;
    edges = 0; cap = 0; idx = cpha ? 8 : 7;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n, t0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v); chk(v == 32'hF800_0015, "R1 ctrl reset", v, 32'hF800_0015);
    rd(3'd4, v); chk(v == 0, "R1 data reset", v, 0);
    chk(cs_o == 3'b111, "R1 selects high", cs_o, 3'b111);
    chk(sclk_o == 0, "R1 sclk idle", sclk_o, 0);

    // R3 select write without start
    wr(3'd0, ctrl(3'b001, 0, 0, 0, 0, 5'd2));
    chk(cs_o == 3'b001, "R3 select write", cs_o, 3'b001);
    rd(3'd0, v); chk(v[1] == 0, "R2 no start without go", v[1], 0);

    // table walk: R2 R4 R5 R6 R7 R9
    foreach (VEC[i]) begin
      logic [4:0] dv; logic lp, ph, pl; logic [7:0] tx, p, exp;
      dv = VEC[i][28:24]; lp = VEC[i][18]; ph = VEC[i][17]; pl = VEC[i][16];
      tx = VEC[i][15:8]; p = VEC[i][7:0];
      exp = lp ? tx : p;
      wr(3'd4, {24'd0, tx});
      wr(3'd0, ctrl(3'b110, 0, lp, pl, ph, dv));
      arm(pl, ph, p);
      wr(3'd0, ctrl(3'b110, 1, lp, pl, ph, dv));
      t0 = cyc;
      wait_idle(t0, n);
      chk(n == 16 * (dv + 1), "R2 R7 busy length", n, 16 * (dv + 1));
      rd(3'd4, v);
      chk(v == {24'd0, exp}, lp ? "R4 R9 loopback byte" : "R6 R9 rx byte", v, exp);
      chk(cap == tx, "R6 mosi msb first", cap, tx);
      chk(edges == 16, "R5 edge count", edges, 16);
      chk(sclk_o == pl, "R5 idle level", sclk_o, pl);
    end

    // R8 writes during a transfer
    wr(3'd4, 32'h0000_00C9);
    wr(3'd0, ctrl(3'b110, 0, 0, 0, 0, 5'd2));
    arm(0, 0, 8'h5B);
    wr(3'd0, ctrl(3'b110, 1, 0, 0, 0, 5'd2));
    t0 = cyc;
    repeat (4) @(negedge clk);
    wr(3'd4, 32'h0000_0011);
    wr(3'd0, ctrl(3'b011, 1, 1, 1, 1, 5'd2));
    chk(cs_o == 3'b011, "R3 select write while busy", cs_o, 3'b011);
    wait_idle(t0, n);
    chk(n == 48, "R8 no restart", n, 48);
    rd(3'd4, v); chk(v == 32'h5B, "R8 data write ignored", v, 32'h5B);
    rd(3'd0, v); chk(v[6:3] == 4'b0000, "R8 mode bits kept", v[6:3], 0);
    chk(sclk_o == 0, "R8 idle level kept", sclk_o, 0);

    // R7 slowest divider, loopback, miso ignored
    wr(3'd4, 32'h0000_0093);
    wr(3'd0, ctrl(3'b111, 0, 1, 0, 0, 5'd31));
    arm(0, 0, 8'h00);
    wr(3'd0, ctrl(3'b111, 1, 1, 0, 0, 5'd31));
    t0 = cyc;
    wait_idle(t0, n);
    chk(n == 512, "R7 slow divider length", n, 512);
    rd(3'd4, v); chk(v == 32'h93, "R4 loopback ignores miso", v, 32'h93);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule